// File: doc/BRIEF.md
# CRT Sync Pulse Generator

This block produces the horizontal and vertical sync pulses of a character-based CRT timing controller. The surrounding controller owns the horizontal and vertical total counters. It hands this block a strobe when the character counter reaches the horizontal sync position, a strobe for every new scan line, and a level that is high while the row counter equals the vertical sync position. Each clock cycle is one character time.

A one-byte width register sets the pulse lengths. A CPU loads it through an index-select strobe followed by a data-write strobe. A 3-bit mode input selects one of five legacy controller behaviours. The modes differ in what a zero width means, in whether the vertical width is fixed at 16 lines, and in whether rewriting the width to zero cuts a running horizontal pulse short. The two 4-bit pulse counters are brought out beside the sync outputs.

Top module: `crt_sync_gen`

## Requirements
- R1: Synchronous active-high reset clears both sync outputs, both counters and the width register. After reset, in mode 2, a horizontal start produces a 16-character pulse.
- R2: A cycle with `cpu_sel_i` high stores `cpu_data_i[4:0]` as the selected index. A later cycle with `cpu_wr_i` high loads `cpu_data_i` into the width register only when the index is 3. A write to any other index leaves the pulse widths unchanged.
- R3: The width register holds the horizontal width in bits 3..0 and the vertical width in bits 7..4. For a nonzero horizontal width W, `hsync_o` rises the cycle after `hstart_i` is sampled and stays high for W cycles. While it is high, `hcnt_o` shows 0, 1, … W-1, and it reads 0 while idle.
- R4: In modes 0 and 1, a horizontal width of 0 suppresses HSYNC.
- R5: In modes 2, 3 and 4, a horizontal width of 0 gives a 16-character HSYNC.
- R6: If the horizontal width is rewritten during a pulse, the counter keeps counting and wraps from 15 to 0. The pulse ends when the incremented count equals the new width.
- R7: In mode 1, a horizontal width of 0 during an active pulse drops `hsync_o` on the next clock.
- R8: `hstart_i` is ignored while HSYNC is active.
- R9: VSYNC starts on a cycle with both `line_i` and `vmatch_i` high. It lasts W scan lines, and `vcnt_o` advances only on `line_i`.
- R10: Modes 1 and 2 ignore bits 7..4 and always give a 16-line VSYNC.
- R11: Modes 0, 3 and 4 use bits 7..4 as the vertical width, and a value of 0 means 16 lines.
- R12: Mode values 5, 6 and 7 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Legacy behaviour select (0..4; 5..7 act as 0) |
| hstart_i | input | 1 | Horizontal counter reached sync position |
| line_i | input | 1 | Scan-line strobe (horizontal total reached) |
| vmatch_i | input | 1 | Row counter equals vertical sync position |
| cpu_sel_i | input | 1 | Index-select write strobe |
| cpu_wr_i | input | 1 | Data write strobe |
| cpu_data_i | input | 8 | CPU write data |
| hsync_o | output | 1 | Horizontal sync pulse |
| vsync_o | output | 1 | Vertical sync pulse |
| hcnt_o | output | 4 | Horizontal sync width counter |
| vcnt_o | output | 4 | Vertical sync width counter |

## Verification
Both counters are outputs, so a wrong count or a missed wrap shows on `hcnt_o` or `vcnt_o` in the very cycle it happens, long before the pulse ends at the wrong time. A wrong mode decode or a wrong register load shows only when a pulse runs. The resulting error in pulse length is seen at the falling edge of `hsync_o` or `vsync_o`, at most 16 characters or 16 lines later. The bench therefore compares every output against a behavioural model on every clock and also measures whole pulse lengths.

// File: rtl/crt_sync_pkg.sv
package crt_sync_pkg;

    localparam int CNT_W  = 4;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    // vertical field in the upper nibble, horizontal field in the lower
    typedef struct packed {
        cnt_t vw;
        cnt_t hw;
    } sync_width_t;

    typedef logic [2:0] mode_t;

    function automatic mode_t mode_norm(mode_t m);
        return (m > 3'd4) ? 3'd0 : m;
    endfunction

    function automatic logic zero_suppresses(mode_t m);
        return (mode_norm(m) == 3'd0) || (mode_norm(m) == 3'd1);
    endfunction

    function automatic logic zero_cancels(mode_t m);
        return mode_norm(m) == 3'd1;
    endfunction

    function automatic logic vwidth_fixed(mode_t m);
        return (mode_norm(m) == 3'd1) || (mode_norm(m) == 3'd2);
    endfunction

endpackage

// File: rtl/crt_sync_regs.sv
module crt_sync_regs
    import crt_sync_pkg::*;
#(
    parameter int unsigned WIDTH_IDX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] din,
    output sync_width_t       width_q
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            width_q <= '0;
        end else begin
            if (sel_wr)
                idx_q <= din[IDX_W-1:0];
            if (data_wr && (idx_q == IDX_W'(WIDTH_IDX)))
                width_q <= sync_width_t'(din);
        end
    end
endmodule

// File: rtl/crt_pulse_ctr.sv
module crt_pulse_ctr
    import crt_sync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic start,
    input  cnt_t width,
    input  logic zero_off,
    input  logic zero_cut,
    output logic active,
    output cnt_t count
);
    cnt_t nxt;
    logic zero_w;

    always_comb begin
        nxt    = count + cnt_t'(1);
        zero_w = (width == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            count  <= '0;
        end else if (active) begin
            if (zero_cut && zero_w) begin
                active <= 1'b0;
                count  <= '0;
            end else if (adv) begin
                if (nxt == width) begin
                    active <= 1'b0;
                    count  <= '0;
                end else begin
                    count <= nxt;
                end
            end
        end else if (start && !(zero_off && zero_w)) begin
            active <= 1'b1;
            count  <= '0;
        end
    end
endmodule

// File: rtl/crt_sync_gen.sv
module crt_sync_gen
    import crt_sync_pkg::*;
#(
    parameter int unsigned WIDTH_IDX = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_i,
    input  logic       hstart_i,
    input  logic       line_i,
    input  logic       vmatch_i,
    input  logic       cpu_sel_i,
    input  logic       cpu_wr_i,
    input  logic [7:0] cpu_data_i,
    output logic       hsync_o,
    output logic       vsync_o,
    output logic [3:0] hcnt_o,
    output logic [3:0] vcnt_o
);
    sync_width_t width_q;
    cnt_t        v_width;
    logic        h_zero_off;
    logic        h_zero_cut;
    logic        v_start;

    crt_sync_regs #(.WIDTH_IDX(WIDTH_IDX)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel_wr  (cpu_sel_i),
        .data_wr (cpu_wr_i),
        .din     (cpu_data_i),
        .width_q (width_q)
    );

    always_comb begin
        h_zero_off = zero_suppresses(mode_i);
        h_zero_cut = zero_cancels(mode_i);
        v_width    = vwidth_fixed(mode_i) ? cnt_t'(0) : width_q.vw;
        v_start    = line_i && vmatch_i;
    end

    crt_pulse_ctr u_hctr (
        .clk      (clk),
        .rst      (rst),
        .adv      (1'b1),
        .start    (hstart_i),
        .width    (width_q.hw),
        .zero_off (h_zero_off),
        .zero_cut (h_zero_cut),
        .active   (hsync_o),
        .count    (hcnt_o)
    );

    crt_pulse_ctr u_vctr (
        .clk      (clk),
        .rst      (rst),
        .adv      (line_i),
        .start    (v_start),
        .width    (v_width),
        .zero_off (1'b0),
        .zero_cut (1'b0),
        .active   (vsync_o),
        .count    (vcnt_o)
    );
endmodule

// File: rtl/crt_sync_chk.sv
module crt_sync_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_i,
    input logic       hstart_i,
    input logic       line_i,
    input logic       hsync_o,
    input logic       vsync_o,
    input logic [3:0] hcnt_o,
    input logic [3:0] vcnt_o,
    input logic [7:0] width_q
);
    logic mode_sup;
    assign mode_sup = (mode_i == 3'd0) || (mode_i == 3'd1) || (mode_i > 3'd4);

    // R3
    hcnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !hsync_o |-> hcnt_o == 4'd0);

    // R3
    hrise_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_o) |-> hcnt_o == 4'd0);

    // R6
    hcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        hsync_o && $past(hsync_o) |-> hcnt_o == 4'($past(hcnt_o) + 4'd1));

    // R4
    hzero_off_chk: assert property (@(posedge clk) disable iff (rst)
        hstart_i && !hsync_o && mode_sup && width_q[3:0] == 4'd0 |=> !hsync_o);

    // R7
    hcancel_chk: assert property (@(posedge clk) disable iff (rst)
        hsync_o && mode_i == 3'd1 && width_q[3:0] == 4'd0 |=> !hsync_o);

    // R9
    vstart_line_chk: assert property (@(posedge clk) disable iff (rst)
        !line_i && !vsync_o |=> !vsync_o);

    // R9
    vcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_i |=> $stable(vcnt_o));
endmodule

bind crt_sync_gen crt_sync_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_i),
    .hstart_i (hstart_i),
    .line_i   (line_i),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .hcnt_o   (hcnt_o),
    .vcnt_o   (vcnt_o),
    .width_q  (width_q)
);

// File: tb/test_crt_sync_gen.sv
module test_crt_sync_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode = 3'd0;
    logic       hstart = 1'b0;
    logic       line = 1'b0;
    logic       vmatch = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] din = 8'd0;
    logic       hsync_o, vsync_o;
    logic [3:0] hcnt_o, vcnt_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    crt_sync_gen i_crt_sync_gen (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .hstart_i   (hstart),
        .line_i     (line),
        .vmatch_i   (vmatch),
        .cpu_sel_i  (sel),
        .cpu_wr_i   (wr),
        .cpu_data_i (din),
        .hsync_o    (hsync_o),
        .vsync_o    (vsync_o),
        .hcnt_o     (hcnt_o),
        .vcnt_o     (vcnt_o)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: lengths and counts as integers
    int m_idx, m_reg, m_hon, m_hc, m_von, m_vc;
    always @(posedge clk) begin
        if (rst) begin
            m_idx = 0; m_reg = 0; m_hon = 0; m_hc = 0; m_von = 0; m_vc = 0;
        end else begin
            int md, hw, vw;
            md = (mode > 4) ? 0 : int'(mode);
            hw = m_reg % 16;
            vw = (md == 1 || md == 2) ? 16 : ((m_reg / 16 == 0) ? 16 : m_reg / 16);
            if (m_hon != 0) begin
                if (md == 1 && hw == 0) begin
                    m_hon = 0; m_hc = 0;
                end else begin
                    m_hc = (m_hc + 1) % 16;
                    if (m_hc == hw) begin m_hon = 0; m_hc = 0; end
                end
            end else if (hstart && !(hw == 0 && md <= 1)) begin
                m_hon = 1; m_hc = 0;
            end
            if (line) begin
                if (m_von != 0) begin
                    m_vc = m_vc + 1;
                    if (m_vc == vw) begin m_von = 0; m_vc = 0; end
                    else m_vc = m_vc % 16;
                end else if (vmatch) begin
                    m_von = 1; m_vc = 0;
                end
            end
            if (wr && m_idx == 3) m_reg = int'(din);
            if (sel) m_idx = int'(din[4:0]);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(hsync_o == m_hon[0] && vsync_o == m_von[0] &&
                  int'(hcnt_o) == m_hc && int'(vcnt_o) == m_vc,
                  "R3/R9 model", {hsync_o, vsync_o, hcnt_o, vcnt_o},
                  m_hon * 512 + m_von * 256 + m_hc * 16 + m_vc);
        end
    end

    task automatic wr_reg(int idx, int val);
        @(negedge clk); sel = 1'b1; din = 8'(idx);
        @(negedge clk); sel = 1'b0; wr = 1'b1; din = 8'(val);
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse_h(int hold, output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (hsync_o) n++;
            hstart = (i < hold);
        end
        hstart = 1'b0;
    endtask

    task automatic pulse_v(int gap, output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (vsync_o) n++;
            line = (i % gap == 0);
            vmatch = (i < 1);
        end
        line = 1'b0; vmatch = 1'b0;
    endtask

    // rewrite width to newv while hcnt_o shows 5
    task automatic pulse_rewrite(int newv, output int n);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (hsync_o) n++;
            hstart = (k == 0);
            sel = (k == 5);
            wr  = (k == 6);
            din = (k == 5) ? 8'd3 : 8'(newv);
        end
        sel = 1'b0; wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!hsync_o && !vsync_o && hcnt_o == 0 && vcnt_o == 0, "R1 reset outputs",
              {hsync_o, vsync_o, hcnt_o, vcnt_o}, 0);
        mode = 3'd2; pulse_h(1, n); check(n == 16, "R1 register zero after reset", n, 16);

        wr_reg(3, 8'h04); mode = 3'd0;
        pulse_h(1, n); check(n == 4, "R3 width 4", n, 4);
        wr_reg(5, 8'h09);
        pulse_h(1, n); check(n == 4, "R2 other index ignored", n, 4);
        wr_reg(3, 8'h0B);
        pulse_h(1, n); check(n == 11, "R2 R3 width 11", n, 11);

        wr_reg(3, 8'h00);
        mode = 3'd0; pulse_h(1, n); check(n == 0, "R4 mode 0 zero", n, 0);
        mode = 3'd1; pulse_h(1, n); check(n == 0, "R4 mode 1 zero", n, 0);
        mode = 3'd3; pulse_h(1, n); check(n == 16, "R5 mode 3 zero", n, 16);
        mode = 3'd4; pulse_h(1, n); check(n == 16, "R5 mode 4 zero", n, 16);
        mode = 3'd5; pulse_h(1, n); check(n == 0, "R12 mode 5 zero", n, 0);
        mode = 3'd7; pulse_h(1, n); check(n == 0, "R12 mode 7 zero", n, 0);

        mode = 3'd0; wr_reg(3, 8'h06);
        pulse_h(3, n); check(n == 6, "R8 retrigger ignored", n, 6);

        wr_reg(3, 8'h08);
        pulse_rewrite(8'h03, n); check(n == 19, "R6 rewrite below count wraps", n, 19);
        wr_reg(3, 8'h08);
        pulse_rewrite(8'h0A, n); check(n == 10, "R6 rewrite above count", n, 10);
        wr_reg(3, 8'h08);
        pulse_rewrite(8'h00, n); check(n == 16, "R6 mode 0 zero rewrite", n, 16);
        mode = 3'd1; wr_reg(3, 8'h08);
        pulse_rewrite(8'h00, n); check(n == 7, "R7 mode 1 zero cancels", n, 7);

        mode = 3'd0; wr_reg(3, 8'h50);
        pulse_v(1, n); check(n == 5, "R9 vertical 5 lines", n, 5);
        wr_reg(3, 8'h30);
        pulse_v(2, n); check(n == 6, "R9 sparse line strobes", n, 6);
        wr_reg(3, 8'h00);
        pulse_v(1, n); check(n == 16, "R11 mode 0 zero is 16", n, 16);
        mode = 3'd3; pulse_v(1, n); check(n == 16, "R11 mode 3 zero is 16", n, 16);
        mode = 3'd4; wr_reg(3, 8'h20);
        pulse_v(1, n); check(n == 2, "R11 mode 4 width 2", n, 2);
        mode = 3'd1; wr_reg(3, 8'h34);
        pulse_v(1, n); check(n == 16, "R10 mode 1 fixed", n, 16);
        mode = 3'd2; pulse_v(1, n); check(n == 16, "R10 mode 2 fixed", n, 16);
        mode = 3'd6; pulse_v(1, n); check(n == 3, "R12 mode 6 vertical", n, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule